// File: doc/BRIEF.md
# Register-Mapped Scan Transaction Bridge

The bridge is a slave register bank on a 32-bit host link. It turns sequences of 32-bit register accesses into single 64-bit scan-communication transactions on an internal request/acknowledge bus. The host stages a 64-bit payload in two 32-bit halves. A write to the command word starts the transaction and also picks its direction.

For a store, the host fills the upper half (offset 0x0) and the lower half (offset 0x1). It then writes the command word (offset 0x2) with the direction flag set. For a load, the host writes the command word with the flag clear. When the internal target acknowledges, the bridge captures the returned 64 bits, and the host reads them back from the same two half registers.

A flag write to offset 0x6 clears the engine. A flag write to offset 0x7 sends a one-cycle reset pulse toward the internal bus.

Top module: `reg_scan_bridge`

## Requirements
- R1: After reset, `bus_req_o`, `busy_o`, `err_o` and `bus_rst_o` are 0, and offsets 0x0, 0x1 and 0x2 read 0.
- R2: While idle, a host write to offset 0x0 (upper half) or 0x1 (lower half) stores the word, and that offset reads it back.
- R3: While idle, a host write to offset 0x2 raises `bus_req_o` and `busy_o` at the next clock edge. `bus_we_o` equals bit 31 of the written word (1 = store, 0 = load), and `bus_addr_o` carries its low `SCOM_AW` bits. `bus_wdata_o` is {upper, lower}. Offset 0x2 reads back the written word.
- R4: `bus_req_o` and the request fields stay steady until a cycle in which `bus_ack_i` is 1. `bus_req_o` and `busy_o` fall at the edge that samples the acknowledge.
- R5: An acknowledge without `bus_err_i` on a load loads `bus_rdata_i[63:32]` into the upper half and `bus_rdata_i[31:0]` into the lower half on the same edge. An acknowledge on a store leaves both halves unchanged.
- R6: While busy, host writes to offsets 0x0, 0x1 and 0x2 are ignored.
- R7: A host write of a word with bit 31 set to offset 0x6 clears, at the next edge, the request, busy, the error flag, both halves and the command word. A write to 0x6 with bit 31 clear has no effect.
- R8: A host write of a word with bit 31 set to offset 0x7 drives `bus_rst_o` high for exactly the next cycle. A write to 0x7 with bit 31 clear leaves it low.
- R9: An acknowledge with `bus_err_i` = 1 sets `err_o`. `err_o` then stays set through later transactions until an engine reset. The erroring acknowledge does not load data.
- R10: Offsets 0x3, 0x4, 0x5, 0x6 and 0x7 read as 0. Writes to 0x3–0x5 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hst_req_i | input | 1 | Host access strobe |
| hst_we_i | input | 1 | Host access is a write |
| hst_addr_i | input | HOST_AW | Host register offset |
| hst_wdata_i | input | HALF_W | Host write word |
| hst_rdata_o | output | HALF_W | Read word for the offset on `hst_addr_i` |
| busy_o | output | 1 | A transaction is outstanding |
| err_o | output | 1 | Sticky error flag |
| bus_req_o | output | 1 | Internal bus request |
| bus_we_o | output | 1 | Internal request is a store |
| bus_addr_o | output | SCOM_AW | Internal address |
| bus_wdata_o | output | 2*HALF_W | Store payload |
| bus_ack_i | input | 1 | Internal acknowledge |
| bus_err_i | input | 1 | Acknowledge carries an error |
| bus_rdata_i | input | 2*HALF_W | Load payload |
| bus_rst_o | output | 1 | Reset pulse toward the internal bus |

## Verification
The bound checker watches every cycle for these properties:
- the request holds steady until it is acknowledged and falls right after;
- a command launches with the right direction;
- the engine reset clears the request and the error;
- the bus reset lasts exactly one cycle;
- the error flag is sticky;
- unmapped offsets read zero.

Some behaviours show only in the bench's scenarios, because the staged halves are visible solely through host reads:
- a load lands in both halves on one edge;
- writes made while busy are dropped;
- an erroring acknowledge leaves the data untouched.

// File: rtl/srb_pkg.sv
package srb_pkg;
  localparam int OFS_DHI  = 0;
  localparam int OFS_DLO  = 1;
  localparam int OFS_CMD  = 2;
  localparam int OFS_ERST = 6;
  localparam int OFS_BRST = 7;

  typedef struct packed {
    logic dhi_wr;
    logic dlo_wr;
    logic cmd_wr;
    logic erst;
    logic brst;
  } srb_strb_t;
endpackage

// File: rtl/srb_decode.sv
module srb_decode
  import srb_pkg::*;
#(
  parameter int HOST_AW = 3,
  parameter int HALF_W  = 32
) (
  input  logic               req_i,
  input  logic               we_i,
  input  logic [HOST_AW-1:0] addr_i,
  input  logic               flag_i,
  input  logic               busy_i,
  input  logic [HALF_W-1:0]  dhi_i,
  input  logic [HALF_W-1:0]  dlo_i,
  input  logic [HALF_W-1:0]  cmd_i,
  output srb_strb_t          strb_o,
  output logic [HALF_W-1:0]  rdata_o
);
  always_comb begin
    strb_o = '0;
    if (req_i && we_i) begin
      case (addr_i)
        HOST_AW'(OFS_DHI):  strb_o.dhi_wr = !busy_i;
        HOST_AW'(OFS_DLO):  strb_o.dlo_wr = !busy_i;
        HOST_AW'(OFS_CMD):  strb_o.cmd_wr = !busy_i;
        HOST_AW'(OFS_ERST): strb_o.erst   = flag_i;
        HOST_AW'(OFS_BRST): strb_o.brst   = flag_i;
        default: ;
      endcase
    end
  end

  // reset registers are write-only
  always_comb begin
    case (addr_i)
      HOST_AW'(OFS_DHI): rdata_o = dhi_i;
      HOST_AW'(OFS_DLO): rdata_o = dlo_i;
      HOST_AW'(OFS_CMD): rdata_o = cmd_i;
      default:           rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/srb_data_stage.sv
module srb_data_stage #(
  parameter int HALF_W = 32,
  localparam int DATA_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [HALF_W-1:0] wdata_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] cap_data_i,
  output logic [HALF_W-1:0] hi_o,
  output logic [HALF_W-1:0] lo_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_o <= '0;
      lo_o <= '0;
    end else if (clr_i) begin
      hi_o <= '0;
      lo_o <= '0;
    end else if (cap_i) begin
      // both halves on one edge
      hi_o <= cap_data_i[DATA_W-1:HALF_W];
      lo_o <= cap_data_i[HALF_W-1:0];
    end else begin
      if (wr_hi_i) hi_o <= wdata_i;
      if (wr_lo_i) lo_o <= wdata_i;
    end
  end
endmodule

// File: rtl/srb_txn_ctrl.sv
module srb_txn_ctrl #(
  parameter int HALF_W  = 32,
  parameter int SCOM_AW = 31
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               cmd_wr_i,
  input  logic [HALF_W-1:0]  wdata_i,
  input  logic               ack_i,
  input  logic               err_i,
  output logic               req_o,
  output logic               we_o,
  output logic [SCOM_AW-1:0] addr_o,
  output logic [HALF_W-1:0]  cmd_o,
  output logic               err_o,
  output logic               cap_o
);
  logic              req_q;
  logic              err_q;
  logic [HALF_W-1:0] cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      err_q <= 1'b0;
      cmd_q <= '0;
    end else if (clr_i) begin
      req_q <= 1'b0;
      err_q <= 1'b0;
      cmd_q <= '0;
    end else if (req_q && ack_i) begin
      req_q <= 1'b0;
      if (err_i) err_q <= 1'b1;
    end else if (cmd_wr_i) begin
      req_q <= 1'b1;
      cmd_q <= wdata_i;
    end
  end

  assign req_o  = req_q;
  assign we_o   = cmd_q[HALF_W-1];
  assign addr_o = cmd_q[SCOM_AW-1:0];
  assign cmd_o  = cmd_q;
  assign err_o  = err_q;
  assign cap_o  = req_q && ack_i && !cmd_q[HALF_W-1] && !err_i;
endmodule

// File: rtl/reg_scan_bridge.sv
module reg_scan_bridge
  import srb_pkg::*;
#(
  parameter int HOST_AW = 3,
  parameter int HALF_W  = 32,
  parameter int SCOM_AW = 31,
  localparam int DATA_W = 2 * HALF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hst_req_i,
  input  logic               hst_we_i,
  input  logic [HOST_AW-1:0] hst_addr_i,
  input  logic [HALF_W-1:0]  hst_wdata_i,
  output logic [HALF_W-1:0]  hst_rdata_o,
  output logic               busy_o,
  output logic               err_o,
  output logic               bus_req_o,
  output logic               bus_we_o,
  output logic [SCOM_AW-1:0] bus_addr_o,
  output logic [DATA_W-1:0]  bus_wdata_o,
  input  logic               bus_ack_i,
  input  logic               bus_err_i,
  input  logic [DATA_W-1:0]  bus_rdata_i,
  output logic               bus_rst_o
);
  srb_strb_t         strb;
  logic [HALF_W-1:0] dhi, dlo, cmd;
  logic              cap;
  logic              brst_q;

  srb_decode #(.HOST_AW(HOST_AW), .HALF_W(HALF_W)) u_decode (
    .req_i   (hst_req_i),
    .we_i    (hst_we_i),
    .addr_i  (hst_addr_i),
    .flag_i  (hst_wdata_i[HALF_W-1]),
    .busy_i  (bus_req_o),
    .dhi_i   (dhi),
    .dlo_i   (dlo),
    .cmd_i   (cmd),
    .strb_o  (strb),
    .rdata_o (hst_rdata_o)
  );

  srb_data_stage #(.HALF_W(HALF_W)) u_data (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (strb.erst),
    .wr_hi_i    (strb.dhi_wr),
    .wr_lo_i    (strb.dlo_wr),
    .wdata_i    (hst_wdata_i),
    .cap_i      (cap),
    .cap_data_i (bus_rdata_i),
    .hi_o       (dhi),
    .lo_o       (dlo)
  );

  srb_txn_ctrl #(.HALF_W(HALF_W), .SCOM_AW(SCOM_AW)) u_txn (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (strb.erst),
    .cmd_wr_i (strb.cmd_wr),
    .wdata_i  (hst_wdata_i),
    .ack_i    (bus_ack_i),
    .err_i    (bus_err_i),
    .req_o    (bus_req_o),
    .we_o     (bus_we_o),
    .addr_o   (bus_addr_o),
    .cmd_o    (cmd),
    .err_o    (err_o),
    .cap_o    (cap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) brst_q <= 1'b0;
    else         brst_q <= strb.brst;
  end

  assign busy_o      = bus_req_o;
  assign bus_wdata_o = {dhi, dlo};
  assign bus_rst_o   = brst_q;
endmodule

// File: rtl/reg_scan_bridge_chk.sv
module reg_scan_bridge_chk
  import srb_pkg::*;
#(
  parameter int HOST_AW = 3,
  parameter int HALF_W  = 32,
  parameter int SCOM_AW = 31
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               hst_req_i,
  input logic               hst_we_i,
  input logic [HOST_AW-1:0] hst_addr_i,
  input logic               wflag_i,
  input logic [HALF_W-1:0]  hst_rdata_o,
  input logic               busy_o,
  input logic               err_o,
  input logic               bus_req_o,
  input logic               bus_we_o,
  input logic [SCOM_AW-1:0] bus_addr_o,
  input logic               bus_ack_i,
  input logic               bus_err_i,
  input logic               bus_rst_o
);
  logic hwr, erst_w, brst_w, cmd_w;
  assign hwr    = hst_req_i && hst_we_i;
  assign erst_w = hwr && hst_addr_i == HOST_AW'(OFS_ERST) && wflag_i;
  assign brst_w = hwr && hst_addr_i == HOST_AW'(OFS_BRST) && wflag_i;
  assign cmd_w  = hwr && hst_addr_i == HOST_AW'(OFS_CMD);

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i && !erst_w |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)); // R4
  AST_ACK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ack_i |=> !bus_req_o && !busy_o); // R4
  AST_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_w && !busy_o |=> bus_req_o && bus_we_o == $past(wflag_i)); // R3
  AST_ENG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erst_w |=> !bus_req_o && !err_o); // R7
  AST_BRST_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brst_w |=> bus_rst_o); // R8
  AST_BRST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_o && !brst_w |=> !bus_rst_o); // R8
  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ack_i && bus_err_i && !erst_w |=> err_o); // R9
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !erst_w |=> err_o); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hst_addr_i > HOST_AW'(OFS_CMD) |-> hst_rdata_o == '0); // R10
endmodule

bind reg_scan_bridge reg_scan_bridge_chk #(
  .HOST_AW(HOST_AW), .HALF_W(HALF_W), .SCOM_AW(SCOM_AW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hst_req_i   (hst_req_i),
  .hst_we_i    (hst_we_i),
  .hst_addr_i  (hst_addr_i),
  .wflag_i     (hst_wdata_i[HALF_W-1]),
  .hst_rdata_o (hst_rdata_o),
  .busy_o      (busy_o),
  .err_o       (err_o),
  .bus_req_o   (bus_req_o),
  .bus_we_o    (bus_we_o),
  .bus_addr_o  (bus_addr_o),
  .bus_ack_i   (bus_ack_i),
  .bus_err_i   (bus_err_i),
  .bus_rst_o   (bus_rst_o)
);

// File: tb/reg_scan_bridge_tb_top.sv
`timescale 1ns/1ps
module reg_scan_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hreq = 1'b0, hwe = 1'b0;
  logic [2:0]  haddr = '0;
  logic [31:0] hwd = '0;
  logic [31:0] hrd;
  logic        busy, err, breq, bwe, brst;
  logic [30:0] baddr;
  logic [63:0] bwd;
  logic        back = 1'b0, berr = 1'b0;
  logic [63:0] brd = '0;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  reg_scan_bridge dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .hst_req_i(hreq), .hst_we_i(hwe), .hst_addr_i(haddr), .hst_wdata_i(hwd), .hst_rdata_o(hrd),
    .busy_o(busy), .err_o(err),
    .bus_req_o(breq), .bus_we_o(bwe), .bus_addr_o(baddr), .bus_wdata_o(bwd),
    .bus_ack_i(back), .bus_err_i(berr), .bus_rdata_i(brd), .bus_rst_o(brst)
  );

  typedef struct packed {
    logic        wr;
    logic [2:0]  ofs;
    logic [31:0] val;   // write data, or expected read data
    logic [3:0]  rq;
  } vec_t;

  // R2 staging and R10 unmapped offsets, all while idle
  localparam vec_t VEC [14] = '{
    '{1'b1, 3'd0, 32'hDEADBEEF, 4'd2},
    '{1'b0, 3'd0, 32'hDEADBEEF, 4'd2},
    '{1'b1, 3'd1, 32'h12345678, 4'd2},
    '{1'b0, 3'd1, 32'h12345678, 4'd2},
    '{1'b0, 3'd0, 32'hDEADBEEF, 4'd2},
    '{1'b1, 3'd3, 32'hFFFFFFFF, 4'd10},
    '{1'b0, 3'd3, 32'h00000000, 4'd10},
    '{1'b0, 3'd4, 32'h00000000, 4'd10},
    '{1'b1, 3'd5, 32'hAAAAAAAA, 4'd10},
    '{1'b0, 3'd5, 32'h00000000, 4'd10},
    '{1'b0, 3'd6, 32'h00000000, 4'd10},
    '{1'b0, 3'd7, 32'h00000000, 4'd10},
    '{1'b0, 3'd0, 32'hDEADBEEF, 4'd10},
    '{1'b0, 3'd1, 32'h12345678, 4'd10}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    hreq = 1'b1; hwe = 1'b1; haddr = a; hwd = d;
    @(negedge clk);
    hreq = 1'b0; hwe = 1'b0;
  endtask

  task automatic host_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    hreq = 1'b1; hwe = 1'b0; haddr = a;
    #1 d = hrd;
    hreq = 1'b0;
  endtask

  task automatic bus_ack(input logic [63:0] rd, input logic e);
    @(negedge clk);
    back = 1'b1; berr = e; brd = rd;
    @(negedge clk);
    back = 1'b0; berr = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 req", breq, 0);
    chk("R1 busy", busy, 0);
    chk("R1 err", err, 0);
    chk("R1 bus_rst", brst, 0);
    host_rd(3'd0, r); chk("R1 dhi", r, 0);
    host_rd(3'd1, r); chk("R1 dlo", r, 0);
    host_rd(3'd2, r); chk("R1 cmd", r, 0);

    for (int i = 0; i < 14; i++) begin
      if (VEC[i].wr) host_wr(VEC[i].ofs, VEC[i].val);
      else begin
        host_rd(VEC[i].ofs, r);
        chk($sformatf("R%0d vec%0d", VEC[i].rq, i), r, VEC[i].val);
      end
    end

    // R3 store launch
    host_wr(3'd2, 32'h80000ABC);
    chk("R3 req", breq, 1);
    chk("R3 busy", busy, 1);
    chk("R3 we", bwe, 1);
    chk("R3 addr", baddr, 31'h00000ABC);
    chk("R3 wdata", bwd, 64'hDEADBEEF_12345678);
    host_rd(3'd2, r); chk("R3 cmd readback", r, 32'h80000ABC);

    // R6 writes while busy are dropped
    host_wr(3'd0, 32'h11111111);
    host_wr(3'd2, 32'h00000055);
    host_rd(3'd0, r); chk("R6 dhi kept", r, 32'hDEADBEEF);
    chk("R6 addr kept", baddr, 31'h00000ABC);
    chk("R6 we kept", bwe, 1);

    // R4 hold until ack
    repeat (3) @(negedge clk);
    chk("R4 req held", breq, 1);
    bus_ack(64'hFFFFFFFF_FFFFFFFF, 1'b0);
    chk("R4 req dropped", breq, 0);
    chk("R4 busy dropped", busy, 0);
    host_rd(3'd0, r); chk("R5 store ack keeps dhi", r, 32'hDEADBEEF);
    host_rd(3'd1, r); chk("R5 store ack keeps dlo", r, 32'h12345678);

    // R5 load capture
    host_wr(3'd2, 32'h00000123);
    chk("R3 load req", breq, 1);
    chk("R3 load we", bwe, 0);
    chk("R3 load addr", baddr, 31'h00000123);
    host_rd(3'd0, r); chk("R5 dhi before ack", r, 32'hDEADBEEF);
    bus_ack(64'hCAFEF00D_0BADC0DE, 1'b0);
    host_rd(3'd0, r); chk("R5 dhi captured", r, 32'hCAFEF00D);
    host_rd(3'd1, r); chk("R5 dlo captured", r, 32'h0BADC0DE);
    chk("R9 err clear", err, 0);

    // R9 error ack
    host_wr(3'd2, 32'h00000007);
    bus_ack(64'h11111111_22222222, 1'b1);
    chk("R9 err set", err, 1);
    host_rd(3'd0, r); chk("R9 dhi untouched", r, 32'hCAFEF00D);
    host_rd(3'd1, r); chk("R9 dlo untouched", r, 32'h0BADC0DE);
    host_wr(3'd2, 32'h80000001);
    bus_ack(64'h0, 1'b0);
    chk("R9 err sticky", err, 1);

    // R7 engine reset
    host_wr(3'd6, 32'h7FFFFFFF);
    chk("R7 no-flag keeps err", err, 1);
    host_wr(3'd2, 32'h00000042);
    chk("R7 busy before reset", busy, 1);
    host_wr(3'd6, 32'h80000000);
    chk("R7 req cleared", breq, 0);
    chk("R7 busy cleared", busy, 0);
    chk("R7 err cleared", err, 0);
    host_rd(3'd0, r); chk("R7 dhi cleared", r, 0);
    host_rd(3'd1, r); chk("R7 dlo cleared", r, 0);
    host_rd(3'd2, r); chk("R7 cmd cleared", r, 0);

    // R8 bus reset pulse
    host_wr(3'd7, 32'h80000000);
    chk("R8 pulse high", brst, 1);
    @(negedge clk);
    chk("R8 pulse one cycle", brst, 0);
    host_wr(3'd7, 32'h00000001);
    chk("R8 no-flag no pulse", brst, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule